// File: doc/BRIEF.md
# Sequential Fixed-Point Fraction Multiplier

This block forms the product of two unsigned fractions. Each operand has its binary point just above its most significant bit, and the result uses the same format. It handles one multiplier bit per clock, starting with the least significant bit. On each step it may add the multiplicand into an accumulator. It then shifts the accumulator right by one place, so the low-order bits of the full product fall away and only the upper word is kept as the fractional result.

A client applies the two operands and pulses `start` while the block is idle. `busy` goes high on the next cycle. After WIDTH steps, `done` pulses for one cycle and `product_o` carries the truncated product. That value stays in place until the next accepted start.

Top module: `frac_mul_seq`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `busy_o` and `done_o` are 0 and `product_o` is 0.
- R2: The product equals floor(mcand × mplier / 2^WIDTH). The operands are the values sampled with the accepted start.
- R3: `done_o` is high in exactly one cycle. That cycle is the WIDTH-th clock edge after the edge that accepted start.
- R4: `busy_o` is high from the edge after an accepted start until `done_o` rises. `busy_o` and `done_o` are never high together.
- R5: A start pulse received while busy is ignored. The running result and its completion time are unchanged.
- R6: Changes on `mcand_i` and `mplier_i` while busy have no effect on the result.
- R7: After `done_o`, `product_o` holds its value until the next accepted start, whatever the operand inputs do.
- R8: A multiplier of all ones gives a result strictly below the multiplicand whenever the multiplicand is nonzero. All ones times all ones gives 2^WIDTH − 2.
- R9: A zero operand on either side gives a zero product.
- R10: A start presented in the same cycle that `done_o` is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a multiply; sampled only when idle |
| mcand_i | input | WIDTH | Multiplicand fraction |
| mplier_i | input | WIDTH | Multiplier fraction |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle completion pulse |
| product_o | output | WIDTH | Truncated fractional product |

## Verification
The assertions assume that `start` and the operand inputs are clean, known values at every rising edge after reset. They also assume that reset is not pulsed in the middle of an operation. The bench drives every input only on falling edges and keeps reset released once the run begins. It deliberately raises `start` and changes the operands while the block is busy, since the block is specified to tolerate that. A 6-bit instance is swept over every operand pair. A 32-bit instance covers the edge values, back-to-back starts and disturbed runs.

// File: rtl/frac_mul_pkg.sv
package frac_mul_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } mul_phase_e;
endpackage

// File: rtl/frac_mul_step.sv
module frac_mul_step #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] acc_i,
    input  logic [WIDTH-1:0] addend_i,
    input  logic             add_en_i,
    output logic [WIDTH-1:0] acc_o
);
    logic [WIDTH:0] sum_wide;

    always_comb begin
        sum_wide = {1'b0, acc_i} + (add_en_i ? {1'b0, addend_i} : '0);
        acc_o    = sum_wide[WIDTH:1];
    end

    // R2
    always_comb begin
        step_floor_chk: assert (acc_o >= (acc_i >> 1));
    end
endmodule

// File: rtl/frac_mul_iter_cnt.sv
module frac_mul_iter_cnt #(
    parameter int WIDTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic step_i,
    output logic last_o
);
    localparam int CNT_W = $clog2(WIDTH + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = CNT_W'(WIDTH);
        end else if (step_i && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last_o = (cnt_q == CNT_W'(1));

    // R3
    cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> cnt_q != '0);

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(WIDTH));
endmodule

// File: rtl/frac_mul_seq.sv
module frac_mul_seq
    import frac_mul_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] mcand_i,
    input  logic [WIDTH-1:0] mplier_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] product_o
);
    typedef struct packed {
        mul_phase_e       phase;
        logic             done;
        logic [WIDTH-1:0] hold;
        logic [WIDTH-1:0] mplier;
        logic [WIDTH-1:0] acc;
    } mul_state_t;

    mul_state_t       s_d, s_q;
    logic             load;
    logic             step;
    logic             cnt_last;
    logic [WIDTH-1:0] acc_step;

    frac_mul_step #(.WIDTH(WIDTH)) u_step (
        .acc_i    (s_q.acc),
        .addend_i (s_q.hold),
        .add_en_i (s_q.mplier[0]),
        .acc_o    (acc_step)
    );

    frac_mul_iter_cnt #(.WIDTH(WIDTH)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .step_i (step),
        .last_o (cnt_last)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        load     = (s_q.phase == PH_IDLE) && start;
        step     = (s_q.phase == PH_RUN);
        if (load) begin
            s_d.hold   = mcand_i;
            s_d.mplier = mplier_i;
            s_d.acc    = '0;
            s_d.phase  = PH_RUN;
        end else if (step) begin
            s_d.mplier = s_q.mplier >> 1;
            s_d.acc    = acc_step;
            if (cnt_last) begin
                s_d.phase = PH_IDLE;
                s_d.done  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o    = (s_q.phase == PH_RUN);
    assign done_o    = s_q.done;
    assign product_o = s_q.acc;

    // R4
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (done_o || $stable(s_q.hold)));

    // R7
    product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start) |=> $stable(product_o));

    // R5
    restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start && !cnt_last) |=> busy_o);
endmodule

// File: tb/test_frac_mul_seq.sv
module test_frac_mul_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] mcand = '0, mplier = '0;
    logic        busy, done;
    logic [31:0] product;

    logic        s_start = 1'b0;
    logic [5:0]  s_mcand = '0, s_mplier = '0;
    logic        s_busy, s_done;
    logic [5:0]  s_product;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #10 clk = ~clk;

    frac_mul_seq #(.WIDTH(32)) i_frac_mul_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .mcand_i(mcand), .mplier_i(mplier),
        .busy_o(busy), .done_o(done), .product_o(product)
    );

    frac_mul_seq #(.WIDTH(6)) i_frac_mul_seq_w6 (
        .clk(clk), .rst_n(rst_n), .start(s_start), .mcand_i(s_mcand), .mplier_i(s_mplier),
        .busy_o(s_busy), .done_o(s_done), .product_o(s_product)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            finish_run();
        end
    end

    // Caller sits at a falling edge. Returns at a falling edge.
    task automatic op32(input logic [31:0] a, input logic [31:0] b, input bit disturb,
                        input bit do_hold, input string tag);
        logic [63:0] full;
        logic [31:0] exp;
        int          seen;
        full  = 64'(a) * 64'(b);
        exp   = full[63:32];
        seen  = 0;
        mcand = a;
        mplier = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, {"R4 busy after start ", tag}, 64'(busy), 64'd1);
        for (int k = 1; k <= 40; k++) begin
            if (disturb && k == 4) begin
                start  = 1'b1;
                mcand  = ~a;
                mplier = ~b;
            end
            if (disturb && k == 5) start = 1'b0;
            if (k == 20) begin
                mcand  = a ^ 32'h5A5A_A5A5;
                mplier = b + 32'd7;
            end
            @(negedge clk);
            if (done) begin
                seen = k;
                break;
            end
        end
        start = 1'b0;
        // R3: done exactly WIDTH edges after acceptance
        check(seen == 32, {"R3 done timing ", tag}, 64'(seen), 64'd32);
        check(busy == 1'b0, {"R4 busy low at done ", tag}, 64'(busy), 64'd0);
        // R2 / R5 / R6: product of the accepted operands
        check(product == exp, {"R2 R5 R6 product ", tag}, 64'(product), 64'(exp));
        if (do_hold) begin
            for (int k = 0; k < 3; k++) begin
                mcand  = mcand + 32'h1234_5678;
                mplier = ~mplier;
                @(negedge clk);
                check(done == 1'b0, {"R3 done one cycle ", tag}, 64'(done), 64'd0);
                check(product == exp, {"R7 product holds ", tag}, 64'(product), 64'(exp));
            end
        end
    endtask

    task automatic op6(input logic [5:0] a, input logic [5:0] b);
        int          seen;
        logic [11:0] full;
        full     = 12'(a) * 12'(b);
        seen     = 0;
        s_mcand  = a;
        s_mplier = b;
        s_start  = 1'b1;
        @(negedge clk);
        s_start = 1'b0;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            if (s_done) begin
                seen = k;
                break;
            end
        end
        check(seen == 6, "R3 w6 done timing", 64'(seen), 64'd6);
        check(s_product == full[11:6], "R2 w6 sweep product", 64'(s_product), 64'(full[11:6]));
    endtask

    initial begin
        #5;
        // R1: reset state
        check(busy == 0 && done == 0 && product == 0, "R1 during reset",
              {busy, done, 30'd0, product}, 64'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && done == 0 && product == 0, "R1 after reset",
              {busy, done, 30'd0, product}, 64'd0);

        op32(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1, "half*half");
        op32(32'h1234_5678, 32'h9ABC_DEF0, 1'b0, 1'b1, "mixed");
        op32(32'hDEAD_BEEF, 32'h0000_0001, 1'b0, 1'b1, "lsb only");
        op32(32'h7654_3210, 32'h0F0F_0F0F, 1'b1, 1'b1, "R5 restart ignored");
        // R8: multiplying by all ones
        op32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, "R8 ones*ones");
        check(product == 32'hFFFF_FFFE, "R8 ones*ones value", 64'(product), 64'hFFFF_FFFE);
        op32(32'h0000_0001, 32'hFFFF_FFFF, 1'b0, 1'b1, "R8 one*ones");
        check(product < 32'h1, "R8 below mcand small", 64'(product), 64'd0);
        op32(32'hC000_0003, 32'hFFFF_FFFF, 1'b0, 1'b1, "R8 mid*ones");
        check(product < 32'hC000_0003, "R8 below mcand mid", 64'(product), 64'hC000_0003);
        // R9: zero operands
        op32(32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 1'b1, "R9 zero mcand");
        op32(32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 1'b1, "R9 zero mplier");
        // R10: back to back, start in the done cycle
        op32(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, 1'b0, "R10 first");
        op32(32'h0F0F_F0F0, 32'hFEDC_BA98, 1'b0, 1'b1, "R10 second");

        for (int a = 0; a < 64; a++) begin
            for (int b = 0; b < 64; b++) begin
                op6(6'(a), 6'(b));
            end
        end
        finish_run();
    end
endmodule